// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Register Bank

This block is the configuration front end of a clock-generation device. A host talks to it over a three- or four-wire serial port. Each transaction starts with a 16-bit instruction and continues with one or more data bytes. The block holds a small set of registers: a serial-port setup register, a readback-source selector, a self-clearing software update strobe, a read-only identification pair, and a power control register whose bits drive the power enables of the rest of the chip.

The power control register is double-buffered. Serial writes land in a pending (shadow) copy. The copy that drives the outputs changes only on an update event. An update event is either a rising edge on the update pin, or a write of 1 to the software update strobe. The host can choose whether reads of a buffered register return the pending value or the value in effect.

The serial port samples its pins with the system clock, so the whole block runs in one clock domain. Serial clock edges are detected after synchronisation, which means the serial clock must be several times slower than the system clock. At the first clock after hard reset, the block latches the startup strap inputs. These latched values are the power register default from then on.

Top module: `spi_shadow_regbank`

## Requirements
- R1: After hard reset, the outputs `pwr_o` equal the `strap_i` value sampled just after reset release, and the setup register at address 0x0000 reads 0x18. A later hard reset samples the straps again.
- R2: The setup register keeps bits [7:4] as the bit-mirror of bits [3:0]: bit7=bit0, bit6=bit1, bit5=bit2, bit4=bit3. Bit 3 always reads 1. On writes, a setting is accepted from either a low-nibble bit or its mirrored high-nibble bit.
- R3: An instruction is 16 bits: bit15 is 1 for read, bits [14:13] give the byte count minus one (3 means stream until chip select rises), and bits [12:0] are the start address. The address steps down by one after each byte in MSB-first order and up by one in LSB-first order.
- R4: A write to the power register at 0x0010 changes only its shadow copy. `pwr_o` does not change until an update event.
- R5: Bit 0 of 0x0004 selects what a read of 0x0010 returns: 1 returns the shadow value, 0 returns the active value.
- R6: One rising edge of `upd_i` copies the shadow into the active register exactly once, however long the pin stays high; a falling edge copies nothing. Writing 1 to bit 0 of 0x0005 does the same copy, and 0x0005 always reads 0.
- R7: Bit 1 of 0x0000 selects LSB-first order. Setting it takes effect from the next transaction. Clearing it takes effect only after an update event.
- R8: Bit 0 of 0x0000 selects four-wire mode. During read data, `sdo_oe_o` is asserted in four-wire mode and `sdio_oe_o` is asserted in three-wire mode. Neither is asserted while chip select is high.
- R9: While bit 2 of 0x0000 is 1, every other register is held at its default: 0x0004 reads 0, and both copies of 0x0010 equal the strap value latched at the last hard reset. The bit does not clear itself.
- R10: `core_en_o` is the inverse of active power bit 1 (full power-down). `dclk_en_o` is 1 only when active power bits 1 and 0 (digital power-down) are both 0.
- R11: 0x0002 reads PART_ID[7:0] and 0x0003 reads PART_ID[15:8]. Writes to them are ignored. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| sclk_i | input | 1 | Serial clock, idles low; data is sampled on the rising edge |
| csb_i | input | 1 | Active-low transaction select |
| sdio_i | input | 1 | Serial data in (shared data line, input side) |
| upd_i | input | 1 | Update request pin, rising-edge sensitive |
| strap_i | input | 8 | Startup strap values, default of the power register |
| sdo_o | output | 1 | Serial read data bit |
| sdio_oe_o | output | 1 | Drive enable of the shared line (three-wire read) |
| sdo_oe_o | output | 1 | Drive enable of the dedicated output pin (four-wire read) |
| pwr_o | output | 8 | Active power control register |
| core_en_o | output | 1 | Enable for all blocks except the serial port |
| dclk_en_o | output | 1 | Clock enable for the digital section |

## Verification
Two behaviours are hard to reach from the ports. The first is the single copy under a held update pin. The bench raises `upd_i`, keeps it high while a new shadow value is written over the serial port, and checks that `pwr_o` keeps the first copy both while the pin is high and after it falls. The second is the asymmetric bit-order rule. The bench switches to LSB-first, then clears the order bit while still in LSB-first order. It then reads the non-palindromic identification bytes in LSB-first order, which proves the old order persisted until the update. Because 0x0000 reads the same in either order, the bench checks order with the identification bytes, not with that register.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int INST_W = 16;
  localparam int CNT_W  = 2;
  localparam int ADDR_W = INST_W - 1 - CNT_W;
  localparam int BYTE_W = 8;
  localparam int BITC_W = $clog2(INST_W);
  localparam int BIDX_W = $clog2(BYTE_W);

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'('h0000);
  localparam logic [ADDR_W-1:0] A_ID_LO = ADDR_W'('h0002);
  localparam logic [ADDR_W-1:0] A_ID_HI = ADDR_W'('h0003);
  localparam logic [ADDR_W-1:0] A_RBSEL = ADDR_W'('h0004);
  localparam logic [ADDR_W-1:0] A_UPD   = ADDR_W'('h0005);
  localparam logic [ADDR_W-1:0] A_PWR   = ADDR_W'('h0010);

  localparam int PD_FULL = 1;
  localparam int PD_DIG  = 0;

  typedef enum logic [1:0] {PH_IDLE, PH_INST, PH_DATA, PH_DONE} phase_e;

  typedef struct packed {
    logic              rd;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr;
  } inst_t;
endpackage

// File: rtl/dbr_sync.sv
module dbr_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dbr_serial.sv
module dbr_serial
  import dbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csb_s,
  input  logic              sdi_s,
  input  logic              lsb_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              dout_o,
  output logic              drive_o
);
  phase_e             ph_q, ph_n;
  logic               sclk_d_q;
  logic [INST_W-1:0]  sh_q, sh_n, shifted;
  logic [BITC_W-1:0]  bc_q, bc_n;
  logic               rd_q, rd_n, strm_q, strm_n, lsb_q, lsb_n;
  logic [CNT_W-1:0]   left_q, left_n;
  logic [ADDR_W-1:0]  ad_q, ad_n, ad_step;
  logic               dout_q, dout_n, drv_q, drv_n;
  logic               wen_q, wen_n;
  logic [ADDR_W-1:0]  wad_q, wad_n;
  logic [BYTE_W-1:0]  wdat_q, wdat_n, byte_in;
  logic [BIDX_W-1:0]  bidx;
  logic               rise, fall;
  inst_t              inst;

  assign rise = sclk_s & ~sclk_d_q;
  assign fall = ~sclk_s & sclk_d_q;

  always_comb begin
    shifted = lsb_q ? {sdi_s, sh_q[INST_W-1:1]} : {sh_q[INST_W-2:0], sdi_s};
    byte_in = lsb_q ? shifted[INST_W-1 -: BYTE_W] : shifted[BYTE_W-1:0];
    inst    = inst_t'(shifted);
    ad_step = lsb_q ? ad_q + ADDR_W'(1) : ad_q - ADDR_W'(1);
    bidx    = lsb_q ? bc_q[BIDX_W-1:0]
                    : BIDX_W'(BYTE_W-1) - bc_q[BIDX_W-1:0];
  end

  // next-state logic
  always_comb begin
    ph_n = ph_q;  sh_n = sh_q;  bc_n = bc_q;  rd_n = rd_q;  strm_n = strm_q;
    lsb_n = lsb_q;  left_n = left_q;  ad_n = ad_q;  dout_n = dout_q;
    drv_n = drv_q;  wen_n = 1'b0;  wad_n = wad_q;  wdat_n = wdat_q;
    if (csb_s) begin
      ph_n  = PH_IDLE;
      drv_n = 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_n  = PH_INST;
          bc_n  = '0;
          lsb_n = lsb_i;
          drv_n = 1'b0;
        end
        PH_INST: if (rise) begin
          sh_n = shifted;
          if (bc_q == BITC_W'(INST_W-1)) begin
            rd_n   = inst.rd;
            left_n = inst.cnt;
            strm_n = &inst.cnt;
            ad_n   = inst.addr;
            bc_n   = '0;
            ph_n   = PH_DATA;
          end else begin
            bc_n = bc_q + BITC_W'(1);
          end
        end
        PH_DATA: begin
          if (rise) begin
            sh_n = shifted;
            if (bc_q == BITC_W'(BYTE_W-1)) begin
              bc_n = '0;
              ad_n = ad_step;
              if (!rd_q) begin
                wen_n  = 1'b1;
                wad_n  = ad_q;
                wdat_n = byte_in;
              end
              if (!strm_q) begin
                if (left_q == '0) begin
                  ph_n  = PH_DONE;
                  drv_n = 1'b0;
                end else begin
                  left_n = left_q - CNT_W'(1);
                end
              end
            end else begin
              bc_n = bc_q + BITC_W'(1);
            end
          end else if (fall && rd_q) begin
            drv_n  = 1'b1;
            dout_n = rd_data_i[bidx];
          end
        end
        default: drv_n = 1'b0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;  sclk_d_q <= 1'b0;  sh_q <= '0;  bc_q <= '0;
      rd_q <= 1'b0;  strm_q <= 1'b0;  lsb_q <= 1'b0;  left_q <= '0;
      ad_q <= '0;  dout_q <= 1'b0;  drv_q <= 1'b0;  wen_q <= 1'b0;
      wad_q <= '0;  wdat_q <= '0;
    end else begin
      ph_q <= ph_n;  sclk_d_q <= sclk_s;  sh_q <= sh_n;  bc_q <= bc_n;
      rd_q <= rd_n;  strm_q <= strm_n;  lsb_q <= lsb_n;  left_q <= left_n;
      ad_q <= ad_n;  dout_q <= dout_n;  drv_q <= drv_n;  wen_q <= wen_n;
      wad_q <= wad_n;  wdat_q <= wdat_n;
    end
  end

  assign rd_addr_o = ad_q;
  assign wr_en_o   = wen_q;
  assign wr_addr_o = wad_q;
  assign wr_data_o = wdat_q;
  assign dout_o    = dout_q;
  assign drive_o   = drv_q;

  // R8: no drive once the transaction select is released
  p_quiet_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csb_s |=> !drv_q);
  // R3: one write strobe per completed byte
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wen_q |=> !wen_q);
  // R3: the address moves only when a byte completes
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA && !rise) |=> $stable(ad_q));
endmodule

// File: rtl/dbr_regs.sv
module dbr_regs
  import dbr_pkg::*;
#(
  parameter logic [2*BYTE_W-1:0] PART_ID = 16'h9B61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] strap_i,
  input  logic              upd_s,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              lsb_o,
  output logic              sdo_en_o,
  output logic [BYTE_W-1:0] pwr_o,
  output logic              core_en_o,
  output logic              dclk_en_o
);
  logic              booted_q, booted_n;
  logic [BYTE_W-1:0] strap_q, strap_n;
  logic              sdo_q, sdo_n, lsb_q, lsb_n, srst_q, srst_n;
  logic              lsb_eff_q, lsb_eff_n;
  logic              rbsel_q, rbsel_n;
  logic [BYTE_W-1:0] pwr_shd_q, pwr_shd_n, pwr_act_q, pwr_act_n, dflt_val;
  logic              upd_d_q;
  logic              upd_pin, upd_sw, upd_evt, dflt_ld;
  logic              wr_cfg, wr_rb, wr_pwr;
  logic              unused_ro_bits;

  assign unused_ro_bits = ^wr_data_i[4:3];

  always_comb begin
    upd_pin  = upd_s & ~upd_d_q;
    wr_cfg   = wr_en_i && (wr_addr_i == A_CFG);
    wr_rb    = wr_en_i && (wr_addr_i == A_RBSEL);
    wr_pwr   = wr_en_i && (wr_addr_i == A_PWR);
    upd_sw   = wr_en_i && (wr_addr_i == A_UPD) && wr_data_i[0];
    upd_evt  = upd_pin | upd_sw;
    dflt_ld  = ~booted_q | srst_q;
    dflt_val = booted_q ? strap_q : strap_i;
  end

  // next-state logic
  always_comb begin
    booted_n  = 1'b1;
    strap_n   = booted_q ? strap_q : strap_i;
    sdo_n     = sdo_q;
    lsb_n     = lsb_q;
    srst_n    = srst_q;
    lsb_eff_n = lsb_eff_q;
    rbsel_n   = rbsel_q;
    pwr_shd_n = pwr_shd_q;
    pwr_act_n = pwr_act_q;

    if (wr_cfg) begin
      sdo_n  = wr_data_i[0] | wr_data_i[7];
      lsb_n  = wr_data_i[1] | wr_data_i[6];
      srst_n = wr_data_i[2] | wr_data_i[5];
    end

    if (wr_cfg && (wr_data_i[1] | wr_data_i[6])) lsb_eff_n = 1'b1;
    else if (upd_evt)                          lsb_eff_n = lsb_q;

    if (dflt_ld) begin
      rbsel_n   = 1'b0;
      pwr_shd_n = dflt_val;
      pwr_act_n = dflt_val;
    end else begin
      if (wr_rb)   rbsel_n   = wr_data_i[0];
      if (wr_pwr)  pwr_shd_n = wr_data_i;
      if (upd_evt) pwr_act_n = pwr_shd_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      booted_q <= 1'b0;  strap_q <= '0;  sdo_q <= 1'b0;  lsb_q <= 1'b0;
      srst_q <= 1'b0;  lsb_eff_q <= 1'b0;  rbsel_q <= 1'b0;
      pwr_shd_q <= '0;  pwr_act_q <= '0;  upd_d_q <= 1'b0;
    end else begin
      booted_q <= booted_n;  strap_q <= strap_n;  sdo_q <= sdo_n;
      lsb_q <= lsb_n;  srst_q <= srst_n;  lsb_eff_q <= lsb_eff_n;
      rbsel_q <= rbsel_n;  pwr_shd_q <= pwr_shd_n;  pwr_act_q <= pwr_act_n;
      upd_d_q <= upd_s;
    end
  end

  // read multiplexer
  always_comb begin
    unique case (rd_addr_i)
      A_CFG:   rd_data_o = {sdo_q, lsb_q, srst_q, 1'b1, 1'b1, srst_q, lsb_q, sdo_q};
      A_ID_LO: rd_data_o = PART_ID[BYTE_W-1:0];
      A_ID_HI: rd_data_o = PART_ID[2*BYTE_W-1:BYTE_W];
      A_RBSEL: rd_data_o = {{(BYTE_W-1){1'b0}}, rbsel_q};
      A_PWR:   rd_data_o = rbsel_q ? pwr_shd_q : pwr_act_q;
      default: rd_data_o = '0;
    endcase
  end

  assign lsb_o     = lsb_eff_q;
  assign sdo_en_o  = sdo_q;
  assign pwr_o     = pwr_act_q;
  assign core_en_o = ~pwr_act_q[PD_FULL];
  assign dclk_en_o = ~pwr_act_q[PD_FULL] & ~pwr_act_q[PD_DIG];

  // R6: an update event copies the pending value
  p_update_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !dflt_ld) |=> pwr_act_q == $past(pwr_shd_q));
  // R4: without update or default load the active copy holds
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !dflt_ld) |=> $stable(pwr_act_q));
  // R6: a held pin yields a single event
  p_pin_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pin |=> !upd_pin);
  // R9: soft reset forces defaults from the latched straps
  p_soft_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (booted_q && srst_q) |=> (pwr_act_q == strap_q && pwr_shd_q == strap_q && !rbsel_q));
  // R9: strap values are not resampled after boot
  p_strap_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    booted_q |=> $stable(strap_q));
  // R7: return to MSB-first only through an update event
  p_msb_on_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lsb_eff_q) |-> $past(upd_evt));
endmodule

// File: rtl/spi_shadow_regbank.sv
module spi_shadow_regbank
  import dbr_pkg::*;
#(
  parameter logic [2*BYTE_W-1:0] PART_ID     = 16'h9B61,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csb_i,
  input  logic              sdio_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] strap_i,
  output logic              sdo_o,
  output logic              sdio_oe_o,
  output logic              sdo_oe_o,
  output logic [BYTE_W-1:0] pwr_o,
  output logic              core_en_o,
  output logic              dclk_en_o
);
  localparam int PIN_W = 4;

  logic [1:0]              rst_sr_q;
  logic                    rst_ni;
  logic [PIN_W-1:0]        pins_s;
  logic                    lsb, sdo_en, wr_en, dout, drive;
  logic [ADDR_W-1:0]       rd_addr, wr_addr;
  logic [BYTE_W-1:0]       rd_data, wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= '0;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_ni = rst_sr_q[1];

  dbr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk(clk), .rst_n(rst_ni),
    .d_i({upd_i, sdio_i, csb_i, sclk_i}), .q_o(pins_s)
  );

  dbr_serial u_serial (
    .clk(clk), .rst_n(rst_ni),
    .sclk_s(pins_s[0]), .csb_s(pins_s[1]), .sdi_s(pins_s[2]),
    .lsb_i(lsb), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .dout_o(dout), .drive_o(drive)
  );

  dbr_regs #(.PART_ID(PART_ID)) u_regs (
    .clk(clk), .rst_n(rst_ni), .strap_i(strap_i), .upd_s(pins_s[3]),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .lsb_o(lsb), .sdo_en_o(sdo_en), .pwr_o(pwr_o),
    .core_en_o(core_en_o), .dclk_en_o(dclk_en_o)
  );

  assign sdo_o     = dout;
  assign sdio_oe_o = drive & ~sdo_en;
  assign sdo_oe_o  = drive & sdo_en;

  // R8: the two drive enables never overlap
  p_oe_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_oe_o));
endmodule

// File: tb/spi_shadow_regbank_bench.sv
module spi_shadow_regbank_bench;
  localparam int          HP = 8;
  localparam logic [15:0] ID = 16'h9B61;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, sclk, csb, sdio, upd;
  logic [7:0] strap, pwr;
  logic       sdo, sdio_oe, sdo_oe, core_en, dclk_en;

  spi_shadow_regbank #(.PART_ID(ID)) u_spi_shadow_regbank (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csb_i(csb), .sdio_i(sdio),
    .upd_i(upd), .strap_i(strap), .sdo_o(sdo), .sdio_oe_o(sdio_oe),
    .sdo_oe_o(sdo_oe), .pwr_o(pwr), .core_en_o(core_en), .dclk_en_o(dclk_en)
  );

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t      exp_q[$];
  logic [7:0] act_q[$];
  event       byte_ev;
  int         n_vec = 0, n_bad = 0;
  bit         seen_io, seen_so, done = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes expected read bytes, shifts the transaction
  task automatic txn(input bit lsb, input bit rd, input logic [12:0] adr,
                     input int nb, input logic [7:0] d0, input logic [7:0] d1,
                     input string tag);
    logic [15:0] ins;
    logic [7:0]  db, cap;
    ins = {rd, 2'(nb - 1), adr};
    cap = '0;
    if (rd) begin
      exp_q.push_back('{d0, tag});
      if (nb > 1) exp_q.push_back('{d1, tag});
    end
    seen_io = 0; seen_so = 0;
    csb = 1'b0; wait_clk(HP);
    for (int i = 0; i < 16; i++) begin
      sdio = lsb ? ins[i] : ins[15-i];
      wait_clk(HP); sclk = 1'b1; wait_clk(HP); sclk = 1'b0;
    end
    for (int b = 0; b < nb; b++) begin
      db = (b == 0) ? d0 : d1;
      for (int i = 0; i < 8; i++) begin
        sdio = rd ? 1'b0 : (lsb ? db[i] : db[7-i]);
        wait_clk(HP);
        if (rd) begin
          cap[lsb ? i : 7-i] = sdo;
          seen_io |= sdio_oe;
          seen_so |= sdo_oe;
        end
        sclk = 1'b1; wait_clk(HP); sclk = 1'b0;
      end
      if (rd) begin
        act_q.push_back(cap);
        ->byte_ev;
      end
    end
    wait_clk(HP); csb = 1'b1; wait_clk(2*HP);
  endtask

  task automatic wr(input bit lsb, input logic [12:0] adr, input logic [7:0] d);
    txn(lsb, 1'b0, adr, 1, d, 8'h00, "");
  endtask

  task automatic pulse_pin();
    upd = 1'b1; wait_clk(10); upd = 1'b0; wait_clk(10);
  endtask

  // monitor: compares produced bytes with the scoreboard
  initial begin : monitor
    forever begin
      @(byte_ev);
      while (act_q.size() > 0) begin : pop_one
        item_t      e;
        logic [7:0] a;
        a = act_q.pop_front();
        if (exp_q.size() == 0) chk(a, 8'hxx, "unexpected read byte");
        else begin
          e = exp_q.pop_front();
          chk(a, e.v, e.tag);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; sclk = 1'b0; csb = 1'b1; sdio = 1'b0; upd = 1'b0; strap = 8'h0C;
    wait_clk(5); rst_n = 1'b1; wait_clk(10);

    chk(pwr, 8'h0C, "R1 power equals straps after reset");
    chk({6'b0, core_en, dclk_en}, 8'h03, "R10 enables with no power-down");
    chk({6'b0, sdio_oe, sdo_oe}, 8'h00, "R8 no drive while deselected");
    txn(0, 1, 13'h0000, 1, 8'h18, 8'h00, "R1 R2 setup register reset value");
    chk({6'b0, seen_io, seen_so}, 8'h02, "R8 three-wire read drives shared line");
    txn(0, 1, 13'h0003, 2, ID[15:8], ID[7:0], "R3 R11 id bytes, descending address");

    wr(0, 13'h0003, 8'hFF);
    txn(0, 1, 13'h0003, 1, ID[15:8], 8'h00, "R11 id write ignored");
    wr(0, 13'h0020, 8'h77);
    txn(0, 1, 13'h0020, 1, 8'h00, 8'h00, "R11 unmapped reads zero");

    wr(0, 13'h0010, 8'h02);
    chk(pwr, 8'h0C, "R4 shadow write leaves active copy");
    txn(0, 1, 13'h0010, 1, 8'h0C, 8'h00, "R5 readback of active value");
    wr(0, 13'h0004, 8'h01);
    txn(0, 1, 13'h0010, 1, 8'h02, 8'h00, "R5 readback of pending value");

    upd = 1'b1; wait_clk(10);
    chk(pwr, 8'h02, "R6 pin edge copies shadow");
    chk({6'b0, core_en, dclk_en}, 8'h00, "R10 full power-down");
    wr(0, 13'h0010, 8'h01);
    chk(pwr, 8'h02, "R6 held pin copies once");
    upd = 1'b0; wait_clk(10);
    chk(pwr, 8'h02, "R6 pin fall copies nothing");

    wr(0, 13'h0005, 8'h01);
    chk(pwr, 8'h01, "R6 software update");
    chk({6'b0, core_en, dclk_en}, 8'h02, "R10 digital power-down only");
    txn(0, 1, 13'h0005, 1, 8'h00, 8'h00, "R6 update strobe reads zero");

    txn(0, 0, 13'h0005, 2, 8'h00, 8'h00, "");
    txn(0, 1, 13'h0004, 1, 8'h00, 8'h00, "R3 descending write reached 0x0004");

    wr(0, 13'h0000, 8'h81);
    txn(0, 1, 13'h0000, 1, 8'h99, 8'h00, "R2 four-wire setting mirrored");
    chk({6'b0, seen_io, seen_so}, 8'h01, "R8 four-wire read drives output pin");
    wr(0, 13'h0000, 8'h18);

    wr(0, 13'h0000, 8'h42);
    txn(1, 1, 13'h0000, 1, 8'h5A, 8'h00, "R2 R7 order bit mirrored, LSB-first read");
    txn(1, 1, 13'h0002, 2, ID[7:0], ID[15:8], "R3 R7 ascending address in LSB-first");
    wr(1, 13'h0000, 8'h18);
    txn(1, 1, 13'h0002, 1, ID[7:0], 8'h00, "R7 LSB-first kept until update");
    pulse_pin();
    txn(0, 1, 13'h0003, 1, ID[15:8], 8'h00, "R7 MSB-first after update");

    strap = 8'hF0;
    wr(0, 13'h0010, 8'h03);
    wr(0, 13'h0005, 8'h01);
    chk(pwr, 8'h03, "R6 software update before soft reset");
    wr(0, 13'h0004, 8'h01);
    wr(0, 13'h0000, 8'h3C);
    chk(pwr, 8'h0C, "R9 soft reset restores latched straps");
    txn(0, 1, 13'h0000, 1, 8'h3C, 8'h00, "R9 soft reset bit stays set");
    txn(0, 1, 13'h0004, 1, 8'h00, 8'h00, "R9 readback select back to default");
    wr(0, 13'h0010, 8'h80);
    wr(0, 13'h0005, 8'h01);
    chk(pwr, 8'h0C, "R9 writes held at default during soft reset");
    wr(0, 13'h0000, 8'h18);
    txn(0, 1, 13'h0010, 1, 8'h0C, 8'h00, "R9 default after soft reset release");

    rst_n = 1'b0; wait_clk(5); rst_n = 1'b1; wait_clk(10);
    chk(pwr, 8'hF0, "R1 straps resampled on hard reset");
    chk({6'b0, core_en, dclk_en}, 8'h03, "R10 enables after second reset");

    wait_clk(10);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule